// File: doc/BRIEF.md
# Three-Channel Timer Register and Latch Interface

This block is the byte-wide register front end that sits between a host bus and three 16-bit counter cores. The host uses a 2-bit address. Address 3 accepts control words. Addresses 0, 1 and 2 carry the count bytes of the channel with that number. Control words configure a channel, freeze its running count in a latch, or, in the read-back form, snapshot count and status for any subset of the channels at once.

Towards each counter core the block presents the configured operating mode and BCD flag. It also presents a one-cycle load strobe with the assembled 16-bit start value and a sampling pulse whenever the channel's live count or out level is consumed. From each core it takes the live count, the out level and a pulse that reports the start value has been taken over. Byte sequencing for reads and for writes is tracked separately per channel. Read data is combinational during the read cycle.

Top module: `timer_regif`

## Requirements
- R1: A control word written to address 3 is decoded as: bits 7:6 the channel (0 to 2), bits 5:4 the access type (1 low byte only, 2 high byte only, 3 low then high), bits 3:1 the mode, and bit 0 BCD. Mode codes 6 and 7 are stored as 2 and 3. From the next cycle the mode is on `ch_mode` (3 bits per channel, channel 0 lowest) and BCD is on `ch_bcd`.
- R2: A control word whose access field is 0 captures that channel's live count into its count latch. It leaves the stored access type, mode and BCD unchanged.
- R3: A control word with bits 7:6 equal to 3 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 at 0 latches the count and bit 4 at 0 latches the status of every selected channel.
- R4: A count latch request is ignored while the channel holds an unread latched count. A status latch request is ignored while it holds an unread status.
- R5: The status byte is out level in bit 7, null count in bit 6, access type in bits 5:4, mode in bits 3:1 and BCD in bit 0.
- R6: A data read returns the pending status first and clears it. Otherwise it returns the latched count in the channel's byte order. Otherwise it returns a byte of the live count.
- R7: In low-then-high access, a written low byte is held without a load. The high byte issues a one-cycle load strobe in the next cycle, carrying {high, low}.
- R8: In low-only access a write loads {8'h00, byte}. In high-only access it loads {byte, 8'h00}.
- R9: Live-count reads in low-then-high access alternate low then high bytes, starting with low. This read toggle is independent of the write toggle.
- R10: A read of address 3 returns 0 and changes no state.
- R11: Null count is set by a control word and by every issued load. It is cleared by the channel's `cnt_loaded` pulse.
- R12: A control word (access not 0) returns both byte toggles of the channel to the low byte and discards its pending latched count and status.
- R13: After reset every channel has access type 3, mode 0, BCD 0, null count 0, no pending latch and both toggles on the low byte. No load strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of bus_rd |
| live_count | input | 48 | Live count of each channel, 16 bits each, channel 0 lowest |
| out_level | input | 3 | Out level of each channel |
| cnt_loaded | input | 3 | Pulse per channel: start value taken over |
| load_stb | output | 3 | One-cycle load strobe per channel |
| load_val | output | 48 | Start value per channel, valid with load_stb |
| ch_mode | output | 9 | Configured mode per channel |
| ch_bcd | output | 3 | Configured BCD flag per channel |
| sample_req | output | 3 | Pulse when a channel's live count or out level is consumed |

## Verification
Most state here is hidden: byte toggles, held low bytes, latch-pending flags. A wrong value surfaces only on the next read or write to that channel. A bad write toggle shows up as a missing, extra or byte-swapped load strobe one cycle after the offending byte. A bad read toggle or a stale latch shows up as a wrong byte in the cycle of the following read. The stimulus therefore interleaves reads, writes, latches and read-backs per channel, so that each piece of hidden state is exposed within a few bus operations.

// File: rtl/timer_regif_pkg.sv
package timer_regif_pkg;
    localparam int NCH    = 3;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } cfg_t;

    typedef struct packed {
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
        logic              wr_hi;
        logic              rd_hi;
        logic [BYTE_W-1:0] hold;
        logic [1:0]        lat_st;
        logic [CNT_W-1:0]  lat_v;
        logic              st_pend;
        logic [BYTE_W-1:0] st_v;
        logic              nul;
        logic              ld_stb;
        logic [CNT_W-1:0]  ld_val;
    } chan_st_t;
endpackage

// File: rtl/timer_regif_dec.sv
module timer_regif_dec
    import timer_regif_pkg::*;
(
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output cfg_t              cfg,
    output logic [NCH-1:0]    ctl_wr,
    output logic [NCH-1:0]    cnt_lat,
    output logic [NCH-1:0]    st_lat,
    output logic [NCH-1:0]    dat_wr,
    output logic [NCH-1:0]    dat_rd
);
    logic [1:0]        sel;
    logic [MODE_W-1:0] raw_mode;

    assign sel      = wdata[7:6];
    assign raw_mode = wdata[3:1];

    always_comb begin
        cfg.acc  = acc_e'(wdata[5:4]);
        cfg.mode = (raw_mode > 3'd5) ? raw_mode - 3'd4 : raw_mode;
        cfg.bcd  = wdata[0];
        ctl_wr   = '0;
        cnt_lat  = '0;
        st_lat   = '0;
        dat_wr   = '0;
        dat_rd   = '0;
        for (int i = 0; i < NCH; i++) begin
            if (wr && addr == 2'd3) begin
                if (sel == 2'd3) begin
                    if (wdata[i+1]) begin
                        cnt_lat[i] = !wdata[5];
                        st_lat[i]  = !wdata[4];
                    end
                end else if (sel == 2'(i)) begin
                    if (wdata[5:4] == 2'd0) cnt_lat[i] = 1'b1;
                    else                    ctl_wr[i]  = 1'b1;
                end
            end
            if (addr == 2'(i)) begin
                dat_wr[i] = wr;
                dat_rd[i] = rd;
            end
        end
    end
endmodule

// File: rtl/timer_regif_chan.sv
module timer_regif_chan
    import timer_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    input  logic              ctl_wr,
    input  logic              cnt_lat,
    input  logic              st_lat,
    input  logic              dat_wr,
    input  logic              dat_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live,
    input  logic              out_lvl,
    input  logic              loaded,
    output logic [BYTE_W-1:0] rdata,
    output logic              sample,
    output logic              ld_stb,
    output logic [CNT_W-1:0]  ld_val,
    output logic [MODE_W-1:0] mode,
    output logic              bcd
);
    chan_st_t st_q, st_d;

    always_comb begin
        st_d        = st_q;
        st_d.ld_stb = 1'b0;
        rdata       = '0;
        sample      = 1'b0;
        if (loaded) st_d.nul = 1'b0;
        if (ctl_wr) begin
            st_d.acc     = cfg.acc;
            st_d.mode    = cfg.mode;
            st_d.bcd     = cfg.bcd;
            st_d.wr_hi   = 1'b0;
            st_d.rd_hi   = 1'b0;
            st_d.lat_st  = 2'd0;
            st_d.st_pend = 1'b0;
            st_d.nul     = 1'b1;
        end else begin
            if (cnt_lat && st_q.lat_st == 2'd0) begin
                st_d.lat_st = st_q.acc;
                st_d.lat_v  = live;
                sample      = 1'b1;
            end
            if (st_lat && !st_q.st_pend) begin
                st_d.st_pend = 1'b1;
                st_d.st_v    = {out_lvl, st_q.nul, st_q.acc, st_q.mode, st_q.bcd};
                sample       = 1'b1;
            end
            if (dat_wr) begin
                case (st_q.acc)
                    ACC_LO: begin
                        st_d.ld_stb = 1'b1;
                        st_d.ld_val = {{BYTE_W{1'b0}}, wdata};
                    end
                    ACC_HI: begin
                        st_d.ld_stb = 1'b1;
                        st_d.ld_val = {wdata, {BYTE_W{1'b0}}};
                    end
                    ACC_WORD: begin
                        if (!st_q.wr_hi) begin
                            st_d.hold  = wdata;
                            st_d.wr_hi = 1'b1;
                        end else begin
                            st_d.ld_stb = 1'b1;
                            st_d.ld_val = {wdata, st_q.hold};
                            st_d.wr_hi  = 1'b0;
                        end
                    end
                    default: ;
                endcase
                if (st_d.ld_stb) st_d.nul = 1'b1;
            end
            if (dat_rd) begin
                if (st_q.st_pend) begin
                    rdata        = st_q.st_v;
                    st_d.st_pend = 1'b0;
                end else if (st_q.lat_st != 2'd0) begin
                    case (st_q.lat_st)
                        2'd1: begin
                            rdata       = st_q.lat_v[BYTE_W-1:0];
                            st_d.lat_st = 2'd0;
                        end
                        2'd2: begin
                            rdata       = st_q.lat_v[CNT_W-1:BYTE_W];
                            st_d.lat_st = 2'd0;
                        end
                        default: begin
                            rdata       = st_q.lat_v[BYTE_W-1:0];
                            st_d.lat_st = 2'd2;
                        end
                    endcase
                end else begin
                    sample = 1'b1;
                    case (st_q.acc)
                        ACC_HI:   rdata = live[CNT_W-1:BYTE_W];
                        ACC_WORD: begin
                            rdata      = st_q.rd_hi ? live[CNT_W-1:BYTE_W]
                                                    : live[BYTE_W-1:0];
                            st_d.rd_hi = ~st_q.rd_hi;
                        end
                        default:  rdata = live[BYTE_W-1:0];
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.acc <= ACC_WORD;
        end else begin
            st_q <= st_d;
        end
    end

    assign ld_stb = st_q.ld_stb;
    assign ld_val = st_q.ld_val;
    assign mode   = st_q.mode;
    assign bcd    = st_q.bcd;
endmodule

// File: rtl/timer_regif.sv
module timer_regif
    import timer_regif_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [1:0]              bus_addr,
    input  logic [BYTE_W-1:0]       bus_wdata,
    output logic [BYTE_W-1:0]       bus_rdata,
    input  logic [NCH*CNT_W-1:0]    live_count,
    input  logic [NCH-1:0]          out_level,
    input  logic [NCH-1:0]          cnt_loaded,
    output logic [NCH-1:0]          load_stb,
    output logic [NCH*CNT_W-1:0]    load_val,
    output logic [NCH*MODE_W-1:0]   ch_mode,
    output logic [NCH-1:0]          ch_bcd,
    output logic [NCH-1:0]          sample_req
);
    cfg_t              cfg;
    logic [NCH-1:0]    ctl_wr, cnt_lat, st_lat, dat_wr, dat_rd;
    logic [BYTE_W-1:0] rd_byte [NCH];

    timer_regif_dec u_dec (
        .wr      (bus_wr),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .cfg     (cfg),
        .ctl_wr  (ctl_wr),
        .cnt_lat (cnt_lat),
        .st_lat  (st_lat),
        .dat_wr  (dat_wr),
        .dat_rd  (dat_rd)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        timer_regif_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg     (cfg),
            .ctl_wr  (ctl_wr[g]),
            .cnt_lat (cnt_lat[g]),
            .st_lat  (st_lat[g]),
            .dat_wr  (dat_wr[g]),
            .dat_rd  (dat_rd[g]),
            .wdata   (bus_wdata),
            .live    (live_count[g*CNT_W +: CNT_W]),
            .out_lvl (out_level[g]),
            .loaded  (cnt_loaded[g]),
            .rdata   (rd_byte[g]),
            .sample  (sample_req[g]),
            .ld_stb  (load_stb[g]),
            .ld_val  (load_val[g*CNT_W +: CNT_W]),
            .mode    (ch_mode[g*MODE_W +: MODE_W]),
            .bcd     (ch_bcd[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (bus_rd && bus_addr == 2'(i)) bus_rdata = rd_byte[i];
    end
endmodule

// File: rtl/timer_regif_chk.sv
module timer_regif_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic [2:0] load_stb,
    input logic [8:0] ch_mode
);
    // R1
    ctl_mode_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3 && bus_wdata[7:6] == 2'd0 && bus_wdata[5:4] != 2'd0)
        |=> ch_mode[2:0] == (($past(bus_wdata[3:1]) > 3'd5) ? $past(bus_wdata[3:1]) - 3'd4
                                                             : $past(bus_wdata[3:1])));
    // R2
    latch_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3 && (bus_wdata[7:6] == 2'd3 || bus_wdata[5:4] == 2'd0))
        |=> $stable(ch_mode));
    // R7
    load_after_data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb != 3'b000) |-> $past(bus_wr && bus_addr != 2'd3));
    // R8
    single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb));
    // R10
    ctl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd3) |-> bus_rdata == 8'h00);
endmodule

bind timer_regif timer_regif_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .load_stb  (load_stb),
    .ch_mode   (ch_mode)
);

// File: tb/timer_regif_tb.sv
`timescale 1ns/1ps
module timer_regif_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] live_count;
    logic [2:0]  out_level = '0;
    logic [2:0]  cnt_loaded = '0;
    logic [2:0]  load_stb;
    logic [47:0] load_val;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;
    logic [2:0]  sample_req;

    logic [15:0] lv_in [3];
    assign live_count = {lv_in[2], lv_in[1], lv_in[0]};

    always #2.5 clk = ~clk;

    timer_regif u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .live_count(live_count), .out_level(out_level), .cnt_loaded(cnt_loaded),
        .load_stb(load_stb), .load_val(load_val), .ch_mode(ch_mode),
        .ch_bcd(ch_bcd), .sample_req(sample_req)
    );

    int n_chk = 0, n_bad = 0;

    // reference state per channel
    logic [1:0]  m_acc  [3];
    logic [2:0]  m_mode [3];
    logic        m_bcd  [3];
    logic        m_wrhi [3];
    logic        m_rdhi [3];
    logic [7:0]  m_hold [3];
    logic [1:0]  m_lst  [3];
    logic [15:0] m_lv   [3];
    logic        m_sp   [3];
    logic [7:0]  m_sv   [3];
    logic        m_nul  [3];

    task automatic chk(input logic ok, input string tag, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin
            m_acc[i] = 2'd3; m_mode[i] = 3'd0; m_bcd[i] = 1'b0;
            m_wrhi[i] = 1'b0; m_rdhi[i] = 1'b0; m_hold[i] = 8'h00;
            m_lst[i] = 2'd0; m_lv[i] = 16'h0; m_sp[i] = 1'b0;
            m_sv[i] = 8'h00; m_nul[i] = 1'b0;
        end
    endtask

    function automatic logic [2:0] map_mode(input logic [2:0] m);
        return (m > 3'd5) ? m - 3'd4 : m;
    endfunction

    task automatic m_latch_cnt(input int i);
        if (m_lst[i] == 2'd0) begin m_lst[i] = m_acc[i]; m_lv[i] = lv_in[i]; end
    endtask

    task automatic m_latch_st(input int i);
        if (!m_sp[i]) begin
            m_sp[i] = 1'b1;
            m_sv[i] = {out_level[i], m_nul[i], m_acc[i], m_mode[i], m_bcd[i]};
        end
    endtask

    // bus write; checks load strobe and configuration after the edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        logic [2:0]  e_mask = 3'b000;
        logic [15:0] e_val  = 16'h0;
        if (a == 2'd3) begin
            if (d[7:6] == 2'd3) begin
                for (int i = 0; i < 3; i++) if (d[i+1]) begin
                    if (!d[5]) m_latch_cnt(i);
                    if (!d[4]) m_latch_st(i);
                end
            end else if (d[5:4] == 2'd0) begin
                m_latch_cnt(int'(d[7:6]));
            end else begin
                int c = int'(d[7:6]);
                m_acc[c] = d[5:4]; m_mode[c] = map_mode(d[3:1]); m_bcd[c] = d[0];
                m_wrhi[c] = 1'b0; m_rdhi[c] = 1'b0; m_lst[c] = 2'd0; m_sp[c] = 1'b0;
                m_nul[c] = 1'b1;
            end
        end else begin
            int c = int'(a);
            case (m_acc[c])
                2'd1: begin e_mask[c] = 1'b1; e_val = {8'h00, d}; end
                2'd2: begin e_mask[c] = 1'b1; e_val = {d, 8'h00}; end
                default: begin
                    if (!m_wrhi[c]) begin m_hold[c] = d; m_wrhi[c] = 1'b1; end
                    else begin e_mask[c] = 1'b1; e_val = {d, m_hold[c]}; m_wrhi[c] = 1'b0; end
                end
            endcase
            if (e_mask != 3'b000) m_nul[c] = 1'b1;
        end
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        chk(load_stb == e_mask, tag, int'(load_stb), int'(e_mask));
        for (int i = 0; i < 3; i++) begin
            if (e_mask[i]) chk(load_val[i*16 +: 16] == e_val, tag,
                               int'(load_val[i*16 +: 16]), int'(e_val));
            chk(ch_mode[i*3 +: 3] == m_mode[i], "R1 mode", int'(ch_mode[i*3 +: 3]), int'(m_mode[i]));
            chk(ch_bcd[i] == m_bcd[i], "R1 bcd", int'(ch_bcd[i]), int'(m_bcd[i]));
        end
    endtask

    // bus read; checks the returned byte and the sampling pulse
    task automatic rd(input logic [1:0] a, input string tag);
        logic [7:0] e = 8'h00;
        logic live_rd = 1'b0;
        if (a != 2'd3) begin
            int c = int'(a);
            if (m_sp[c]) begin e = m_sv[c]; m_sp[c] = 1'b0; end
            else if (m_lst[c] != 2'd0) begin
                case (m_lst[c])
                    2'd1: begin e = m_lv[c][7:0];  m_lst[c] = 2'd0; end
                    2'd2: begin e = m_lv[c][15:8]; m_lst[c] = 2'd0; end
                    default: begin e = m_lv[c][7:0]; m_lst[c] = 2'd2; end
                endcase
            end else begin
                live_rd = 1'b1;
                case (m_acc[c])
                    2'd1: e = lv_in[c][7:0];
                    2'd2: e = lv_in[c][15:8];
                    default: begin
                        e = m_rdhi[c] ? lv_in[c][15:8] : lv_in[c][7:0];
                        m_rdhi[c] = ~m_rdhi[c];
                    end
                endcase
            end
        end
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(bus_rdata == e, tag, int'(bus_rdata), int'(e));
        if (live_rd) chk(sample_req[a] == 1'b1, "R6 sample", int'(sample_req), 1 << a);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic loaded_pulse(input logic [2:0] m);
        @(negedge clk);
        cnt_loaded = m;
        @(posedge clk); #1;
        cnt_loaded = 3'b000;
        for (int i = 0; i < 3; i++) if (m[i]) m_nul[i] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h0051_7e2a));
        lv_in[0] = 16'h1234; lv_in[1] = 16'hA5C3; lv_in[2] = 16'h0F0E;
        out_level = 3'b101;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R13: reset state
        chk(load_stb == 3'b000, "R13 strobe", int'(load_stb), 0);
        chk(ch_mode == 9'h0, "R13 mode", int'(ch_mode), 0);
        chk(ch_bcd == 3'b000, "R13 bcd", int'(ch_bcd), 0);
        wr(2'd3, 8'hE2, "R3");             // read-back: status of channel 0
        rd(2'd0, "R13 status");            // expect 0xB0
        rd(2'd0, "R9 live lo");
        rd(2'd0, "R9 live hi");

        // R1, R7: word write, mode 2
        wr(2'd3, 8'h34, "R1");
        wr(2'd0, 8'h78, "R7 low held");
        wr(2'd0, 8'h56, "R7 word load");
        // R1 mode 7 -> 3 with BCD; R8 low-only
        wr(2'd3, 8'h5F, "R1");
        chk(ch_mode[5:3] == 3'd3, "R1 fold", int'(ch_mode[5:3]), 3);
        wr(2'd1, 8'hAB, "R8 low only");
        // R8 high-only
        wr(2'd3, 8'hA0, "R1");
        wr(2'd2, 8'hCD, "R8 high only");

        // R2: count latch, live value moves afterwards
        wr(2'd3, 8'h00, "R2");
        chk(ch_mode[2:0] == 3'd2, "R2 mode kept", int'(ch_mode[2:0]), 2);
        lv_in[0] = 16'h9999;
        rd(2'd0, "R2 latched lo");
        rd(2'd0, "R2 latched hi");

        // R4: second latch ignored
        wr(2'd3, 8'h00, "R2");
        lv_in[0] = 16'h4321;
        wr(2'd3, 8'h00, "R4");
        rd(2'd0, "R4 first value lo");
        rd(2'd0, "R4 first value hi");

        // R3, R5, R6: read-back of count and status on channels 0 and 2
        wr(2'd3, 8'hCA, "R3");
        rd(2'd0, "R6 status first");
        rd(2'd0, "R6 latched lo");
        rd(2'd0, "R6 latched hi");
        rd(2'd0, "R6 live");
        rd(2'd2, "R5 status");
        rd(2'd2, "R6 latched hi only");
        rd(2'd2, "R6 live hi only");

        // R11: null count cleared by loaded pulse
        loaded_pulse(3'b001);
        wr(2'd3, 8'hE2, "R3");
        rd(2'd0, "R11 status");
        wr(2'd0, 8'h11, "R9 write toggle");
        wr(2'd3, 8'hE2, "R3");
        rd(2'd0, "R11 set by load? no, word pending");

        // R9, R10: independent toggles, address 3 read is inert
        rd(2'd0, "R9 live");
        rd(2'd3, "R10 zero");
        rd(2'd0, "R10 toggle kept");
        wr(2'd0, 8'h22, "R7 completes word");

        // R12: control word drops latches and toggles
        wr(2'd0, 8'h33, "R12 low pending");
        wr(2'd3, 8'h00, "R2");
        wr(2'd3, 8'hE2, "R3");
        rd(2'd0, "R9 live lo");
        wr(2'd3, 8'h36, "R12");
        rd(2'd0, "R12 live after reset");
        wr(2'd0, 8'h44, "R12 low again");
        wr(2'd0, 8'h55, "R12 load");

        // random mix
        for (int k = 0; k < 1500; k++) begin
            int r = int'($urandom % 10);
            for (int i = 0; i < 3; i++) lv_in[i] = 16'($urandom);
            if (($urandom % 8) == 0) out_level = 3'($urandom);
            case (r)
                0, 1:    wr(2'd3, {2'($urandom % 3), 6'($urandom)}, "R1 random ctl");
                2, 3, 4: wr(2'($urandom % 3), 8'($urandom), "R7 R8 random write");
                5, 6, 7: rd(2'($urandom % 4), "R6 random read");
                8:       loaded_pulse(3'($urandom));
                default: wr(2'd3, {2'b11, 6'($urandom)}, "R3 random read-back");
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule